// File: doc/BRIEF.md
# Interval Timer with Compare-Match Clear

The block is an 8-bit up-counter that produces a periodic interrupt request. A free-running prescaler inside the block derives eight count-enable strobes from the system clock. A 3-bit select input picks one of them as the count clock. While the run input is high, the counter steps once per selected strobe. When the counter equals the compare register, the next strobe returns it to zero and counting continues. The same edge raises a one-cycle interrupt pulse, so the pulses repeat every (N + 1) count clocks, where N is the compare value.

Software loads the compare value through a simple write strobe while the timer is stopped. Valid compare values run from 01H to FFH. A write made while counting is refused and sets a sticky error flag. Lowering the run input holds the counter at zero, so every restart counts from zero.

Top module: `ivl_timer`

## Requirements
- R1: After reset the counter output is 00H, the interrupt output is 0 and the error flag is 0.
- R2: With select 0 and run high, the counter rises by one on every system clock starting from 00H. The first edge with run high takes it to 01H.
- R3: The interrupt output is a single-cycle pulse. Successive pulses are exactly (N + 1) x D system clocks apart, where N is the compare value and D is the division chosen by the select input.
- R4: The interrupt pulse is high in the same cycle that the counter shows 00H after showing N. The sample before the pulse shows N.
- R5: While run is low, the counter reads 00H and no interrupt is raised. After run rises again, counting restarts from 00H.
- R6: A compare write made while run is low takes effect for the next run.
- R7: A compare write made while run is high leaves the compare value unchanged and sets the error flag. The flag then stays at 1 until reset.
- R8: After reset the compare value is FFH, so with select 0 the first interrupt comes 256 clocks after run rises.
- R9: The select encoding is 0 to 7, giving divisions of 1, 2, 4, 8, 16, 64, 256 and 1024 of the system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Count-clock select (R9 encoding) |
| run | input | 1 | Count enable; low holds the counter at zero |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| count | output | 8 | Current counter value |
| irq | output | 1 | One-cycle interval interrupt request |
| cmp_err | output | 1 | Sticky flag: compare write refused while running |

## Verification
The bench measures the gap between interrupt pulses for every select value. This would expose a wrong prescaler tap, a period of N instead of N + 1, or a counter that stops at the match instead of clearing. It checks the counter value on the samples on both sides of each pulse. A design that pulsed one cycle early or late, or that wrapped to 01H, would fail that check. It writes the compare register while running and then re-measures the period. A design that accepted the write would show a new interval or a missing error flag. It also checks that lowering run zeroes the counter at once, which catches a design that merely freezes the count.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  localparam int NUM_SRC = 8;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int DIV_W   = 10;

  // log2 of the division ratio for each select code
  function automatic int div_exp(input int idx);
    case (idx)
      0: div_exp = 0;
      1: div_exp = 1;
      2: div_exp = 2;
      3: div_exp = 3;
      4: div_exp = 4;
      5: div_exp = 6;
      6: div_exp = 8;
      default: div_exp = 10;
    endcase
  endfunction
endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
  parameter int NSRC = ivl_pkg::NUM_SRC,
  parameter int DW   = ivl_pkg::DIV_W
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSRC-1:0] ticks
);
  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_tap
    localparam int E = ivl_pkg::div_exp(i);
    if (E == 0) begin : g_full
      assign ticks[i] = 1'b1;
    end else begin : g_div
      assign ticks[i] = &div_q[E-1:0];
    end
  end

  // R9: the fastest source is active on every cycle
  always_ff @(posedge clk) begin
    if (!rst) assert_fast_tap_R9: assert (ticks[0]);
  end
endmodule

// File: rtl/ivl_clksel.sv
module ivl_clksel #(
  parameter int NSRC = ivl_pkg::NUM_SRC,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] ticks,
  input  logic [SW-1:0]   sel,
  output logic            tick
);
  always_comb tick = ticks[sel];
endmodule

// File: rtl/ivl_counter.sv
module ivl_counter #(
  parameter int CW = 8,
  parameter logic [CW-1:0] CMP_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  output logic [CW-1:0] cnt_q,
  output logic          irq_q,
  output logic          err_q
);
  logic [CW-1:0] cmp_q;
  logic          hit;

  always_comb hit = (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!run) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (hit) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= CW'(cnt_q + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= CMP_RST;
      err_q <= 1'b0;
    end else if (cmp_wr) begin
      if (run) err_q <= 1'b1;
      else     cmp_q <= cmp_wdata;
    end
  end

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cnt_q == '0));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_q && cmp_q != '0) |=> !irq_q);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0 && !irq_q));
  assert_no_tick_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
  assert_cmp_locked_R7: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(cmp_q));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int CNT_W = 8,
  parameter int NSRC  = ivl_pkg::NUM_SRC,
  localparam int SW   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    clk_sel,
  input  logic             run,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             cmp_err
);
  logic [NSRC-1:0] ticks;
  logic            tick;

  ivl_prescaler #(.NSRC(NSRC), .DW(ivl_pkg::DIV_W)) u_pre (
    .clk(clk), .rst(rst), .ticks(ticks));

  ivl_clksel #(.NSRC(NSRC)) u_sel (
    .ticks(ticks), .sel(clk_sel), .tick(tick));

  ivl_counter #(.CW(CNT_W), .CMP_RST({CNT_W{1'b1}})) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cnt_q(count), .irq_q(irq), .err_q(cmp_err));
endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = '0;
  logic       run = 1'b0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic [7:0] count;
  logic       irq;
  logic       cmp_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .run(run),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .count(count), .irq(irq), .cmp_err(cmp_err));

  function automatic int div_of(input int s);
    case (s)
      0: return 1;    1: return 2;   2: return 4;   3: return 8;
      4: return 16;   5: return 64;  6: return 256; default: return 1024;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [7:0] v);
    @(negedge clk);
    cmp_wr = 1'b1; cmp_wdata = v;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; cmp_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    check("R1 err", cmp_err, 0);
  endtask

  task automatic t_default_cmp();
    int k;
    do_reset();
    clk_sel = 3'd0;
    run = 1'b1;
    k = 0;
    do begin
      @(negedge clk); k++;
    end while (!irq && k < 400);
    check("R8 first irq delay", k, 256);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_step();
    write_cmp(8'd5);
    clk_sel = 3'd0;
    run = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R2 step", count, i);
      check("R2 no irq", irq, 0);
    end
    @(negedge clk);
    check("R4 wrap count", count, 0);
    check("R4 wrap irq", irq, 1);
    @(negedge clk);
    check("R2 after wrap", count, 1);
    check("R3 pulse width", irq, 0);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_interval(input int s, input int n);
    int k;
    int prev;
    int gap;
    write_cmp(8'(n));
    clk_sel = 3'(s);
    run = 1'b1;
    k = 0; prev = 0;
    do begin
      prev = count; @(negedge clk); k++;
    end while (!irq && k < 20000);
    check("R4 before wrap", prev, n);
    check("R4 at wrap", count, 0);
    gap = 0;
    @(negedge clk); gap++;
    check("R3 pulse width", irq, 0);
    while (!irq && gap < 20000) begin
      @(negedge clk); gap++;
    end
    check($sformatf("R3 R9 interval sel=%0d", s), gap, (n + 1) * div_of(s));
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stop_restart();
    int seen;
    write_cmp(8'd10);
    clk_sel = 3'd0;
    run = 1'b1;
    repeat (7) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check("R5 cleared", count, 0);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (irq || count != 0) seen++;
    end
    check("R5 idle quiet", seen, 0);
    run = 1'b1;
    @(negedge clk);
    check("R5 restart from zero", count, 1);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_locked_write();
    int gap;
    write_cmp(8'd3);
    check("R6 err clear", cmp_err, 0);
    clk_sel = 3'd0;
    run = 1'b1;
    @(negedge clk);
    cmp_wr = 1'b1; cmp_wdata = 8'd9;
    @(negedge clk);
    cmp_wr = 1'b0;
    check("R7 err set", cmp_err, 1);
    while (!irq) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk); gap++;
    end while (!irq && gap < 100);
    check("R7 cmp unchanged", gap, 4);
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 err sticky", cmp_err, 1);
    do_reset();
    check("R1 err after reset", cmp_err, 0);
  endtask

  initial begin
    t_reset_state();
    t_default_cmp();
    t_step();
    for (int s = 0; s < 8; s++) t_interval(s, 2);
    t_interval(0, 255);
    t_interval(3, 1);
    t_interval(6, 7);
    t_stop_restart();
    t_locked_write();
    t_interval(1, 4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule